// File: doc/BRIEF.md
# Double-Buffered Command Queue Manager

This block sits between a host microcontroller and a bus-cycle command executor. It owns two equal command buffers. While the executor drains one of them, the host refills the other through a narrow write port. Each command takes a fixed number of byte slots, one byte for each CPU bus cycle that the command drives, so a three-cycle store uses three bytes. The executor sees the current byte and its position inside the command. It pulses a consume strobe to move to the next byte.

The manager clears a buffer's ready state when the executor consumes the final byte of that buffer's last committed command. In the same cycle it flips the active buffer and raises a refill interrupt. The interrupt stays high until the host acknowledges it. At power-up buffer 0 is active but not ready, so nothing runs until the host commits a command count for it. If the executor finishes a buffer while the other one is not ready, an underrun flag is raised and the executor is told to idle. It resumes when the host commits the empty buffer. The host may not write into a buffer that is both active and ready. Such writes are dropped and an error flag is raised.

Top module: `cmdbuf_mgr`

## Requirements
- R1: After reset the active buffer is 0, `exe_valid`, `irq`, `underrun` and `host_err` are all low, and the executor cursor points at byte 0.
- R2: Byte writes (`host_op`=0) fill a buffer without making it ready. A buffer becomes ready only through a count commit (`host_op`=1, `host_wdata` = number of commands). `exe_valid` is high exactly while the active buffer is ready, so after reset nothing runs until buffer 0 is committed.
- R3: Command c, byte p, of a buffer is stored at byte index c*SLOT_BYTES+p (`host_idx`). The executor is shown the bytes in ascending index order, each byte once per `exe_next` strobe, with `exe_pidx` = p running 0..SLOT_BYTES-1.
- R4: A strobe that consumes byte SLOT_BYTES-1 of command count-1 clears that buffer's ready state. On the next cycle `act_buf` has toggled, `irq` is high, and the cursor is back at byte 0 of the other buffer.
- R5: `irq` stays high until an acknowledge write (`host_op`=2). The acknowledge clears `irq`, `underrun` and `host_err`. A swap in the same cycle keeps `irq` set. `host_op`=3 has no effect.
- R6: A byte write or commit aimed at the buffer that is active and ready is dropped, and `host_err` is set. The data shown to the executor does not change.
- R7: A swap onto a buffer that is not ready (counting a commit in the same cycle as ready) sets `underrun` and leaves `exe_valid` low. A later commit of that buffer restarts execution from its byte 0.
- R8: A commit whose count is 0 or greater than DEPTH is dropped (the buffer stays not ready) and `host_err` is set.
- R9: `exe_next` while `exe_valid` is low has no effect on the cursor or the active buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_op | input | 2 | 0 byte write, 1 count commit, 2 acknowledge, 3 none |
| host_buf | input | 1 | Target buffer for byte write / commit |
| host_idx | input | IDX_W | Byte index inside the buffer |
| host_wdata | input | 8 | Byte data or command count |
| exe_next | input | 1 | Executor consumed the presented byte |
| exe_valid | output | 1 | Active buffer holds commands to execute |
| exe_param | output | 8 | Current command byte |
| exe_pidx | output | PIDX_W | Position of the byte within its command |
| act_buf | output | 1 | Index of the active buffer |
| irq | output | 1 | Refill interrupt to the host |
| underrun | output | 1 | Swap found the next buffer not ready |
| host_err | output | 1 | Rejected host write seen |

## Verification
The bound checker verifies on every cycle the rules that depend only on the current and previous cycle. It checks that each change of the active buffer comes with the interrupt, that the interrupt and the error flag stay set until acknowledged, that a write into the draining buffer or a zero count raises the error, that the underrun edge coincides with idling, that the byte position stays inside the slot, and that consume strobes have no effect while idle. The bench scenarios are needed for everything that depends on buffer contents and long sequences. That covers the exact byte order across full and short buffers, the swap after precisely the committed count, the restart after an underrun from byte 0, and the proof that dropped writes and dropped commits left the data and the ready state untouched.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;
   localparam int CNT_W = 8;

   typedef enum logic [1:0] {
      HOP_BYTE   = 2'd0,
      HOP_COMMIT = 2'd1,
      HOP_ACK    = 2'd2,
      HOP_NONE   = 2'd3
   } host_op_e;
endpackage

// File: rtl/cmdbuf_store.sv
`timescale 1ns/1ps
module cmdbuf_store #(
   parameter int BUF_BYTES = 96,
   parameter int IDX_W     = 7
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             wr_buf,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             rd_buf,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);
   logic [7:0] bank_q [2];
   logic       idx_in_range;

   assign idx_in_range = ({1'b0, wr_idx} < (IDX_W+1)'(BUF_BYTES));

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [7:0] mem [BUF_BYTES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_buf == b[0]) && idx_in_range)
            mem[wr_idx] <= wr_data;
      end
      assign bank_q[b] = mem[rd_idx];
   end

   assign rd_data = bank_q[rd_buf];
endmodule

// File: rtl/cmdbuf_cursor.sv
`timescale 1ns/1ps
module cmdbuf_cursor
   import cmdbuf_pkg::*;
#(
   parameter int SLOT_BYTES = 3,
   parameter int PIDX_W     = 2,
   parameter int CIDX_W     = 5,
   parameter int IDX_W      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt,
   output logic [IDX_W-1:0]  byte_idx,
   output logic [PIDX_W-1:0] pidx,
   output logic              last
);
   logic [CIDX_W-1:0] cidx_q;
   logic [IDX_W-1:0]  bidx_q;
   logic              slot_end;

   assign last = slot_end && (CNT_W'(cidx_q) == (cnt - CNT_W'(1)));

   if (SLOT_BYTES == 1) begin : g_single
      assign slot_end = 1'b1;
      assign pidx     = '0;
   end else begin : g_multi
      logic [PIDX_W-1:0] p_q;
      assign slot_end = (p_q == PIDX_W'(SLOT_BYTES - 1));
      assign pidx     = p_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            p_q <= '0;
         else if (step)
            p_q <= slot_end ? '0 : p_q + PIDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cidx_q <= '0;
         bidx_q <= '0;
      end else if (step) begin
         if (last) begin
            cidx_q <= '0;
            bidx_q <= '0;
         end else begin
            bidx_q <= bidx_q + IDX_W'(1);
            if (slot_end)
               cidx_q <= cidx_q + CIDX_W'(1);
         end
      end
   end

   assign byte_idx = bidx_q;
endmodule

// File: rtl/cmdbuf_ctrl.sv
`timescale 1ns/1ps
module cmdbuf_ctrl
   import cmdbuf_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [1:0]       host_op,
   input  logic             host_buf,
   input  logic [7:0]       host_wdata,
   input  logic             drained,
   output logic             byte_wr,
   output logic             act,
   output logic             act_rdy,
   output logic [CNT_W-1:0] act_cnt,
   output logic             irq,
   output logic             underrun,
   output logic             err
);
   logic [1:0]       rdy_q;
   logic [CNT_W-1:0] cnt_q [2];
   logic             act_q, irq_q, urun_q, err_q;
   logic             op_byte, op_commit, op_ack, hit_active, cnt_ok, commit, bad, other_ready;

   assign op_byte    = host_we && (host_op == HOP_BYTE);
   assign op_commit  = host_we && (host_op == HOP_COMMIT);
   assign op_ack     = host_we && (host_op == HOP_ACK);
   assign hit_active = (host_buf == act_q) && rdy_q[act_q];
   assign cnt_ok     = (host_wdata != 8'd0) && (host_wdata <= 8'(DEPTH));
   assign byte_wr    = op_byte && !hit_active;
   assign commit     = op_commit && !hit_active && cnt_ok;
   assign bad        = ((op_byte || op_commit) && hit_active) ||
                       (op_commit && !hit_active && !cnt_ok);
   assign other_ready = rdy_q[!act_q] || (commit && (host_buf != act_q));

   for (genvar b = 0; b < 2; b++) begin : g_state
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdy_q[b] <= 1'b0;
            cnt_q[b] <= '0;
         end else if (drained && (act_q == b[0])) begin
            rdy_q[b] <= 1'b0;
         end else if (commit && (host_buf == b[0])) begin
            rdy_q[b] <= 1'b1;
            cnt_q[b] <= host_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         irq_q  <= 1'b0;
         urun_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (drained) act_q <= !act_q;
         irq_q  <= (irq_q && !op_ack) || drained;
         urun_q <= (urun_q && !op_ack) || (drained && !other_ready);
         err_q  <= (err_q && !op_ack) || bad;
      end
   end

   assign act      = act_q;
   assign act_rdy  = rdy_q[act_q];
   assign act_cnt  = cnt_q[act_q];
   assign irq      = irq_q;
   assign underrun = urun_q;
   assign err      = err_q;
endmodule

// File: rtl/cmdbuf_mgr.sv
`timescale 1ns/1ps
module cmdbuf_mgr
   import cmdbuf_pkg::*;
#(
   parameter int SLOT_BYTES = 3,
   parameter int DEPTH      = 32,
   localparam int BUF_BYTES = SLOT_BYTES * DEPTH,
   localparam int IDX_W     = $clog2(BUF_BYTES),
   localparam int PIDX_W    = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
   localparam int CIDX_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_op,
   input  logic              host_buf,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [7:0]        host_wdata,
   input  logic              exe_next,
   output logic              exe_valid,
   output logic [7:0]        exe_param,
   output logic [PIDX_W-1:0] exe_pidx,
   output logic              act_buf,
   output logic              irq,
   output logic              underrun,
   output logic              host_err
);
   if (DEPTH < 32 || DEPTH > 255) begin : g_bad_depth
      $error("cmdbuf_mgr: DEPTH must lie in 32..255");
   end
   if (SLOT_BYTES < 1 || SLOT_BYTES > 8) begin : g_bad_slot
      $error("cmdbuf_mgr: SLOT_BYTES must lie in 1..8");
   end

   logic             byte_wr, act, act_rdy, step, last;
   logic [CNT_W-1:0] act_cnt;
   logic [IDX_W-1:0] rd_idx;

   assign step = exe_next && act_rdy;

   cmdbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_op(host_op),
      .host_buf(host_buf), .host_wdata(host_wdata), .drained(step && last),
      .byte_wr(byte_wr), .act(act), .act_rdy(act_rdy), .act_cnt(act_cnt),
      .irq(irq), .underrun(underrun), .err(host_err)
   );

   cmdbuf_cursor #(
      .SLOT_BYTES(SLOT_BYTES), .PIDX_W(PIDX_W), .CIDX_W(CIDX_W), .IDX_W(IDX_W)
   ) u_cursor (
      .clk(clk), .rst_n(rst_n), .step(step), .cnt(act_cnt),
      .byte_idx(rd_idx), .pidx(exe_pidx), .last(last)
   );

   cmdbuf_store #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_store (
      .clk(clk), .wr_en(byte_wr), .wr_buf(host_buf), .wr_idx(host_idx),
      .wr_data(host_wdata), .rd_buf(act), .rd_idx(rd_idx), .rd_data(exe_param)
   );

   assign exe_valid = act_rdy;
   assign act_buf   = act;
endmodule

// File: rtl/cmdbuf_mgr_chk.sv
`timescale 1ns/1ps
module cmdbuf_mgr_chk #(
   parameter int SLOT_BYTES = 3,
   parameter int PIDX_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [1:0]        host_op,
   input logic              host_buf,
   input logic [7:0]        host_wdata,
   input logic              exe_next,
   input logic              exe_valid,
   input logic [PIDX_W-1:0] exe_pidx,
   input logic              act_buf,
   input logic              irq,
   input logic              underrun,
   input logic              host_err
);
   logic ack;
   assign ack = host_we && (host_op == 2'd2);

   p_pidx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(exe_pidx) < SLOT_BYTES);

   p_swap_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_buf != $past(act_buf)) |-> irq);

   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);

   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_err && !ack) |=> host_err);

   p_active_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_op == 2'd0 && host_buf == act_buf && exe_valid) |=> host_err);

   p_underrun_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> !exe_valid);

   p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_op == 2'd1 && host_wdata == 8'd0) |=> host_err);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!exe_valid && !host_we && exe_next) |=>
         (!exe_valid && $stable(act_buf) && $stable(exe_pidx)));
endmodule

bind cmdbuf_mgr cmdbuf_mgr_chk #(.SLOT_BYTES(SLOT_BYTES), .PIDX_W(PIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_op(host_op),
   .host_buf(host_buf), .host_wdata(host_wdata), .exe_next(exe_next),
   .exe_valid(exe_valid), .exe_pidx(exe_pidx), .act_buf(act_buf),
   .irq(irq), .underrun(underrun), .host_err(host_err)
);

// File: tb/tb_cmdbuf_mgr.sv
`timescale 1ns/1ps
module tb_cmdbuf_mgr;
   localparam int SLOT = 3;
   localparam int DEP  = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_op = 2'd3;
   logic       host_buf = 1'b0;
   logic [6:0] host_idx = '0;
   logic [7:0] host_wdata = '0;
   logic       exe_next = 1'b0;
   logic       exe_valid, act_buf, irq, underrun, host_err;
   logic [7:0] exe_param;
   logic [1:0] exe_pidx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // row = {buffer, command count, seed}
   localparam logic [15:0] ROWS [4] = '{
      {1'b0, 7'd2,  8'h10},
      {1'b1, 7'd32, 8'h40},
      {1'b0, 7'd1,  8'hA0},
      {1'b1, 7'd5,  8'h03}
   };

   always #4 clk = ~clk;

   cmdbuf_mgr #(.SLOT_BYTES(SLOT), .DEPTH(DEP)) dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_op(host_op),
      .host_buf(host_buf), .host_idx(host_idx), .host_wdata(host_wdata),
      .exe_next(exe_next), .exe_valid(exe_valid), .exe_param(exe_param),
      .exe_pidx(exe_pidx), .act_buf(act_buf), .irq(irq),
      .underrun(underrun), .host_err(host_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   task automatic hwr(input logic [1:0] op, input logic b, input int idx, input logic [7:0] d);
      host_we = 1'b1; host_op = op; host_buf = b; host_idx = 7'(idx); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0; host_op = 2'd3;
   endtask

   task automatic fill(input logic b, input int n, input logic [7:0] seed);
      for (int k = 0; k < n * SLOT; k++) hwr(2'd0, b, k, seed + 8'(k));
      hwr(2'd1, b, 0, 8'(n));
   endtask

   task automatic drain(input int n, input logic [7:0] seed);
      for (int k = 0; k < n * SLOT; k++) begin
         chk("R3", "valid", 32'(exe_valid), 32'd1);
         chk("R3", "param", 32'(exe_param), 32'(seed + 8'(k)));
         chk("R3", "pidx",  32'(exe_pidx), 32'(k % SLOT));
         exe_next = 1'b1;
         @(negedge clk);
         exe_next = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "act_buf", 32'(act_buf), 32'd0);
      chk("R1", "valid", 32'(exe_valid), 32'd0);
      chk("R1", "irq", 32'(irq), 32'd0);
      chk("R1", "underrun", 32'(underrun), 32'd0);
      chk("R1", "err", 32'(host_err), 32'd0);
      chk("R1", "pidx", 32'(exe_pidx), 32'd0);

      // R2: byte writes alone do not start execution
      hwr(2'd0, 1'b0, 0, 8'h55);
      chk("R2", "valid before commit", 32'(exe_valid), 32'd0);
      chk("R2", "no error on startup fill", 32'(host_err), 32'd0);

      for (int i = 0; i < 4; i++) begin
         fill(ROWS[i][15], int'(ROWS[i][14:8]), ROWS[i][7:0]);
         if (i == 0) begin
            chk("R2", "valid after commit", 32'(exe_valid), 32'd1);
            chk("R2", "first byte", 32'(exe_param), 32'(ROWS[0][7:0]));
         end else begin
            drain(int'(ROWS[i-1][14:8]), ROWS[i-1][7:0]);
            chk("R4", "act toggled", 32'(act_buf), 32'(!ROWS[i-1][15]));
            chk("R4", "irq raised", 32'(irq), 32'd1);
            chk("R7", "no underrun", 32'(underrun), 32'd0);
            chk("R4", "next buffer runs", 32'(exe_valid), 32'd1);
            repeat (3) @(negedge clk);
            chk("R5", "irq held", 32'(irq), 32'd1);
            hwr(2'd3, 1'b0, 0, 8'h00);
            chk("R5", "op3 no effect", 32'(irq), 32'd1);
            hwr(2'd2, 1'b0, 0, 8'h00);
            chk("R5", "irq acked", 32'(irq), 32'd0);
         end
      end
      drain(int'(ROWS[3][14:8]), ROWS[3][7:0]);
      chk("R7", "act back to 0", 32'(act_buf), 32'd0);
      chk("R7", "underrun set", 32'(underrun), 32'd1);
      chk("R7", "idle", 32'(exe_valid), 32'd0);
      chk("R4", "irq on last swap", 32'(irq), 32'd1);

      // R9: strobes while idle are ignored
      repeat (3) begin
         exe_next = 1'b1; @(negedge clk); exe_next = 1'b0;
      end
      chk("R9", "act unchanged", 32'(act_buf), 32'd0);
      hwr(2'd2, 1'b0, 0, 8'h00);
      chk("R5", "ack clears underrun", 32'(underrun), 32'd0);
      chk("R5", "ack clears irq", 32'(irq), 32'd0);
      fill(1'b0, 2, 8'h80);
      chk("R7", "resume valid", 32'(exe_valid), 32'd1);
      chk("R9", "resume at byte 0", 32'(exe_param), 32'h80);
      chk("R9", "resume pidx 0", 32'(exe_pidx), 32'd0);

      // R6: write into the draining buffer
      hwr(2'd0, 1'b0, 0, 8'hEE);
      chk("R6", "err set", 32'(host_err), 32'd1);
      chk("R6", "data kept", 32'(exe_param), 32'h80);
      hwr(2'd2, 1'b0, 0, 8'h00);
      chk("R5", "ack clears err", 32'(host_err), 32'd0);

      // R8: bad counts
      hwr(2'd1, 1'b1, 0, 8'd0);
      chk("R8", "zero count err", 32'(host_err), 32'd1);
      hwr(2'd2, 1'b0, 0, 8'h00);
      hwr(2'd1, 1'b1, 0, 8'(DEP + 1));
      chk("R8", "oversize count err", 32'(host_err), 32'd1);
      drain(2, 8'h80);
      chk("R8", "buffer 1 stayed not ready", 32'(underrun), 32'd1);
      chk("R8", "idle after swap", 32'(exe_valid), 32'd0);
      chk("R4", "act now 1", 32'(act_buf), 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule